// File: doc/BRIEF.md
# Command Posting and Completion Register Port

This block is the device-side register window through which a host hands work to a device and collects the results. A host writes 32-bit command descriptor addresses into a request register, and each write lands in an inbound queue. Device logic drains that queue one entry at a time. Going the other way, device completion logic pushes 32-bit completion words into an outbound queue, and the host drains it by reading a reply register.

The window also provides four more registers. An interrupt status register shows a pending flag and a sticky overflow flag. A reply interrupt mask register uses inverted polarity, so writing zero enables the interrupt. A doorbell register forwards a one-cycle pulse to the device. A scratchpad register reports when the device is ready. Two read-only configuration pointers are also readable. One interrupt line goes to the host.

A build-time parameter chooses whether the mask bit and the pending bit both sit at bit 3 or both sit at bit 2. Host software written for either variant can then use the block unchanged.

Top module: `cmdq_port`

## Requirements
- R1: After reset, both queues are empty. `req_valid` and `irq` are low, the status register reads 0, the scratchpad reads 0 and the mask register reads with its mask bit set (0x08 in the default variant).
- R2: A host write to offset 0x40 appends the written word to the inbound queue. The device sees the oldest entry on `req_addr` while `req_valid` is high and removes it with a one-cycle `req_pop`, so entries leave in first-in, first-out order.
- R3: A host read of offset 0x44 while the outbound queue is empty returns 0xFFFFFFFF and leaves all queue state unchanged.
- R4: A host read of offset 0x44 while the outbound queue holds data returns the oldest completion word and removes it. Words come out in push order with every bit intact, including the error flag at bit 1.
- R5: The pending bit of the status register (offset 0x30) is 1 whenever the outbound queue is non-empty, whatever the mask. `irq` is high exactly when the pending bit is set and the mask bit at offset 0x34 is clear.
- R6: Each queue holds 16 entries. A request write while the inbound queue is full is discarded and sets a sticky overflow flag at status bit 0. A host write to the status register with bit 0 set clears that flag.
- R7: `cpl_full` is high while the outbound queue holds 16 entries, and a `cpl_push` in that state is discarded.
- R8: The scratchpad register (offset 0xB0) reads 0 until `dev_ready` has been high at a clock edge. From then on it reads 0xFFFF0000.
- R9: A host write to offset 0x20 makes `bell_pulse` high for exactly the following cycle, with `bell_data` carrying the written word. Reads of offset 0x20 return 0.
- R10: Reads of the request register (0x40), and reads or writes of any unmapped offset, return 0 and leave both queues unchanged.
- R11: Offsets 0xB4 and 0xB8 read back the build-time configuration pointer values (default 0x00000010 and 0x00000100). Writes to them have no effect.
- R12: With the alternate variant selected, the mask bit and the pending bit both sit at bit 2 (value 0x04) rather than bit 3 (value 0x08).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; a read has side effects at the clock edge |
| addr | input | 8 | Host byte offset |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, valid in the same cycle as `rd_en` |
| req_valid | output | 1 | Inbound queue is non-empty |
| req_addr | output | 32 | Oldest inbound command address |
| req_pop | input | 1 | Device removes the oldest inbound entry |
| cpl_push | input | 1 | Device appends a completion word |
| cpl_word | input | 32 | Completion word to append |
| cpl_full | output | 1 | Outbound queue is full |
| dev_ready | input | 1 | Device initialisation is complete |
| bell_pulse | output | 1 | One-cycle doorbell strobe |
| bell_data | output | 32 | Word written to the doorbell |
| irq | output | 1 | Reply interrupt to the host |

## Verification
The hardest state to reach from the ports is a full inbound queue that then receives one more request write. The bench reaches it with sixteen back-to-back host writes and no device pops, then issues a seventeenth write. It then drains the queue through `req_pop` to show that exactly the first sixteen words are still present and in order. The same pattern fills the outbound queue from the device side to check `cpl_full` and the discarded push. A second instance built with the alternate variant shares every input, so each status and mask read compares the two bit positions in the same cycle.

// File: rtl/cmdq_port.sv
module cmdq_port #(
  parameter int          DEPTH     = 16,
  parameter bit          ALT_BITS  = 1'b0,
  parameter logic [31:0] CFG_PTR_A = 32'h0000_0010,
  parameter logic [31:0] CFG_PTR_B = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        req_valid,
  output logic [31:0] req_addr,
  input  logic        req_pop,
  input  logic        cpl_push,
  input  logic [31:0] cpl_word,
  output logic        cpl_full,
  input  logic        dev_ready,
  output logic        bell_pulse,
  output logic [31:0] bell_data,
  output logic        irq
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IRQ = ALT_BITS ? 2 : 3;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  localparam logic [7:0] A_BELL = 8'h20, A_STAT = 8'h30, A_MASK = 8'h34,
                         A_REQ  = 8'h40, A_REP  = 8'h44, A_SCR  = 8'hB0,
                         A_CFGA = 8'hB4, A_CFGB = 8'hB8;

  logic [31:0]   in_mem [DEPTH];
  logic [31:0]   out_mem[DEPTH];
  logic [PW-1:0] in_wp, in_rp, out_wp, out_rp;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          mask_q, ovf_q, ready_q;

  wire in_push  = wr_en && addr == A_REQ && in_cnt != FULL;
  wire in_drop  = wr_en && addr == A_REQ && in_cnt == FULL;
  wire in_pop   = req_pop && in_cnt != '0;
  wire out_push = cpl_push && out_cnt != FULL;
  wire out_pop  = rd_en && addr == A_REP && out_cnt != '0;
  wire pend     = out_cnt != '0;

  assign req_valid = in_cnt != '0;
  assign req_addr  = in_mem[in_rp];
  assign cpl_full  = out_cnt == FULL;
  assign irq       = pend && !mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      mask_q <= 1'b1; ovf_q <= 1'b0; ready_q <= 1'b0;
      bell_pulse <= 1'b0; bell_data <= '0;
    end else begin
      if (in_push) begin
        in_mem[in_wp] <= wdata;
        in_wp <= in_wp + 1'b1;
      end
      if (in_pop) in_rp <= in_rp + 1'b1;
      in_cnt <= in_cnt + CW'(in_push) - CW'(in_pop);

      if (out_push) begin
        out_mem[out_wp] <= cpl_word;
        out_wp <= out_wp + 1'b1;
      end
      if (out_pop) out_rp <= out_rp + 1'b1;
      out_cnt <= out_cnt + CW'(out_push) - CW'(out_pop);

      if (in_drop) ovf_q <= 1'b1;
      else if (wr_en && addr == A_STAT && wdata[0]) ovf_q <= 1'b0;

      if (wr_en && addr == A_MASK) mask_q <= wdata[IRQ];
      if (dev_ready) ready_q <= 1'b1;

      bell_pulse <= wr_en && addr == A_BELL;
      if (wr_en && addr == A_BELL) bell_data <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_STAT: begin rdata[0] = ovf_q; rdata[IRQ] = pend; end
        A_MASK: rdata[IRQ] = mask_q;
        A_REP:  rdata = pend ? out_mem[out_rp] : 32'hFFFF_FFFF;
        A_SCR:  rdata = ready_q ? 32'hFFFF_0000 : 32'h0;
        A_CFGA: rdata = CFG_PTR_A;
        A_CFGB: rdata = CFG_PTR_B;
        default: rdata = '0;
      endcase
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= FULL && out_cnt <= FULL);
  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_REQ && in_cnt == FULL && !req_pop) |=> in_cnt == FULL && ovf_q);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_en && addr == A_STAT)) |=> ovf_q);
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_REP && out_cnt == '0 && !cpl_push) |=> out_cnt == '0);
  assert_bell_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_pulse && !(wr_en && addr == A_BELL)) |=> !bell_pulse);
  assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> out_cnt != '0);
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
endmodule

// File: tb/cmdq_port_bench.sv
module cmdq_port_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, rd_en = 0, req_pop = 0, cpl_push = 0, dev_ready = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, cpl_word = '0;
  logic [31:0] rdata, req_addr, bell_data, rdata_b, req_addr_b, bell_data_b;
  logic        req_valid, cpl_full, bell_pulse, irq;
  logic        req_valid_b, cpl_full_b, bell_pulse_b, irq_b;
  int          errors = 0, checks = 0;
  logic [31:0] rv, rvb;

  always #10 clk = ~clk;

  cmdq_port u_cmdq_port (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .req_valid, .req_addr,
    .req_pop, .cpl_push, .cpl_word, .cpl_full, .dev_ready, .bell_pulse,
    .bell_data, .irq);

  cmdq_port #(.ALT_BITS(1'b1)) u_cmdq_port_alt (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata(rdata_b),
    .req_valid(req_valid_b), .req_addr(req_addr_b), .req_pop, .cpl_push,
    .cpl_word, .cpl_full(cpl_full_b), .dev_ready, .bell_pulse(bell_pulse_b),
    .bell_data(bell_data_b), .irq(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] db);
    rd_en = 1; addr = a;
    #1 d = rdata; db = rdata_b;
    @(posedge clk); @(negedge clk);
    rd_en = 0; addr = '0;
  endtask

  task automatic dev_push(input logic [31:0] w);
    cpl_push = 1; cpl_word = w;
    @(posedge clk); @(negedge clk);
    cpl_push = 0; cpl_word = '0;
  endtask

  task automatic dev_pop();
    req_pop = 1;
    @(posedge clk); @(negedge clk);
    req_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 req_valid", {31'b0, req_valid}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(8'h30, rv, rvb); chk("R1 status", rv, 32'h0);
    bus_rd(8'hB0, rv, rvb); chk("R1 scratch", rv, 32'h0);
    bus_rd(8'h34, rv, rvb); chk("R1 mask", rv, 32'h8);
    chk("R12 alt mask", rvb, 32'h4);
  endtask

  task automatic t_request();
    bus_wr(8'h40, 32'hA000_0100);
    bus_wr(8'h40, 32'hA000_0200);
    chk("R2 valid", {31'b0, req_valid}, 32'h1);
    chk("R2 head0", req_addr, 32'hA000_0100);
    dev_pop();
    chk("R2 head1", req_addr, 32'hA000_0200);
    dev_pop();
    chk("R2 empty", {31'b0, req_valid}, 32'h0);
  endtask

  task automatic t_empty_reply();
    bus_rd(8'h44, rv, rvb); chk("R3 empty read", rv, 32'hFFFF_FFFF);
    bus_rd(8'h30, rv, rvb); chk("R3 no pending", rv, 32'h0);
    dev_push(32'h1234_5678);
    bus_rd(8'h44, rv, rvb); chk("R3 next word intact", rv, 32'h1234_5678);
  endtask

  task automatic t_reply_order();
    dev_push(32'h0000_1000);
    dev_push(32'h0000_2002);
    bus_rd(8'h44, rv, rvb); chk("R4 first", rv, 32'h0000_1000);
    bus_rd(8'h44, rv, rvb); chk("R4 error bit", rv, 32'h0000_2002);
    bus_rd(8'h44, rv, rvb); chk("R4 drained", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    dev_push(32'h55);
    bus_rd(8'h30, rv, rvb); chk("R5 pending masked", rv, 32'h8);
    chk("R12 alt pending", rvb, 32'h4);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    bus_wr(8'h34, 32'h0);
    chk("R5 irq on", {31'b0, irq}, 32'h1);
    chk("R12 alt irq on", {31'b0, irq_b}, 32'h1);
    bus_rd(8'h44, rv, rvb);
    chk("R5 irq off when empty", {31'b0, irq}, 32'h0);
    bus_wr(8'h34, 32'h8);
    bus_rd(8'h34, rv, rvb); chk("R5 mask readback", rv, 32'h8);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) bus_wr(8'h40, 32'hC000_0000 + i);
    bus_wr(8'h40, 32'hDEAD_BEEF);
    bus_rd(8'h30, rv, rvb); chk("R6 overflow flag", rv, 32'h1);
    for (int i = 0; i < 16; i++) begin
      chk("R6 kept entry", req_addr, 32'hC000_0000 + i);
      dev_pop();
    end
    chk("R6 dropped extra", {31'b0, req_valid}, 32'h0);
    bus_wr(8'h30, 32'h1);
    bus_rd(8'h30, rv, rvb); chk("R6 flag cleared", rv, 32'h0);
  endtask

  task automatic t_out_full();
    for (int i = 0; i < 16; i++) dev_push(32'hE000_0000 + i);
    chk("R7 full", {31'b0, cpl_full}, 32'h1);
    dev_push(32'hBAD0_BAD0);
    for (int i = 0; i < 16; i++) begin
      bus_rd(8'h44, rv, rvb); chk("R7 word", rv, 32'hE000_0000 + i);
    end
    bus_rd(8'h44, rv, rvb); chk("R7 dropped push", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_ready();
    bus_rd(8'hB0, rv, rvb); chk("R8 not ready", rv, 32'h0);
    dev_ready = 1; @(posedge clk); @(negedge clk); dev_ready = 0;
    bus_rd(8'hB0, rv, rvb); chk("R8 ready", rv, 32'hFFFF_0000);
  endtask

  task automatic t_bell();
    bus_wr(8'h20, 32'hB011_0001);
    chk("R9 pulse", {31'b0, bell_pulse}, 32'h1);
    chk("R9 data", bell_data, 32'hB011_0001);
    @(posedge clk); @(negedge clk);
    chk("R9 single cycle", {31'b0, bell_pulse}, 32'h0);
    bus_rd(8'h20, rv, rvb); chk("R9 read zero", rv, 32'h0);
  endtask

  task automatic t_unmapped();
    bus_wr(8'h40, 32'h7777_0001);
    dev_push(32'h6666_0001);
    bus_rd(8'h40, rv, rvb); chk("R10 req read", rv, 32'h0);
    bus_rd(8'h50, rv, rvb); chk("R10 unmapped read", rv, 32'h0);
    bus_wr(8'h48, 32'hFFFF_FFFF);
    chk("R10 inbound intact", req_addr, 32'h7777_0001);
    dev_pop();
    chk("R10 inbound one entry", {31'b0, req_valid}, 32'h0);
    bus_rd(8'h44, rv, rvb); chk("R10 outbound intact", rv, 32'h6666_0001);
  endtask

  task automatic t_cfg();
    bus_wr(8'hB4, 32'h1);
    bus_rd(8'hB4, rv, rvb); chk("R11 cfg a", rv, 32'h10);
    bus_rd(8'hB8, rv, rvb); chk("R11 cfg b", rv, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_request();
    t_empty_reply();
    t_reply_order();
    t_irq();
    t_overflow();
    t_out_full();
    t_ready();
    t_bell();
    t_unmapped();
    t_cfg();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule